// File: doc/BRIEF.md
# Per-Function Interrupt Mask Change Detector

This block watches the interrupt mask state of a set of functions and records every change that firmware or a host makes to it. For each function it observes a vector of message-interrupt mask bits and a single extended-table function mask bit. It keeps a copy of both from the previous clock cycle. Whenever a mask moves from 1 to 0 or from 0 to 1, it latches a sticky status bit for that function and that direction.

Physical and virtual functions are handled the same way. There are four per-function status vectors: message mask cleared, message mask set, function mask cleared and function mask set. Software clears any bit by writing 1 to it through a per-vector clear strobe. Each vector is reduced to one summary flag, which can drive a local interrupt. A flag stays high until every bit of its vector has been cleared.

Two enable inputs control recording. One gates the message-mask events and the other gates the function-mask events. The logic that stores the masks themselves sits outside this block.

Top module: `mask_chg_det`

## Requirements
- R1: While rst_n is low and right after its release, all four status vectors and all four summary flags read 0.
- R2: If one or more bits of function f's message mask (msi_mask[f*MSI_BITS +: MSI_BITS]) go from 1 to 0 between two clock edges while msi_en is 1, bit f of sts_msi_off is 1 after the second edge.
- R3: If one or more bits of function f's message mask go from 0 to 1 between two clock edges while msi_en is 1, bit f of sts_msi_on is 1 after the second edge.
- R4: A single change in which some bits of a function's message mask fall and others rise sets both sts_msi_off[f] and sts_msi_on[f].
- R5: A 1-to-0 change of msix_mask[f] while msix_en is 1 sets sts_msix_off[f]. A 0-to-1 change sets sts_msix_on[f]. Neither change touches the message-mask vectors.
- R6: A change seen while msi_en is 0 records no message-mask event, and a change seen while msix_en is 0 records no function-mask event. The previous-cycle copy keeps tracking while recording is disabled, so raising an enable later does not replay an old change.
- R7: A status bit stays 1 until a cycle in which its clear strobe bit is 1. That edge drives it to 0. Clear bits that are 0 have no effect.
- R8: When a new event for a bit and a clear of that bit occur at the same edge, the bit stays 1.
- R9: Each summary flag (any_msi_off, any_msi_on, any_msix_off, any_msix_on) equals the OR of its status vector in the same cycle. It therefore stays 1 until the last set bit is cleared.
- R10: The first clock edge after reset release only samples the masks and records no event, whatever mask values were present during reset.
- R11: A change in function f sets only bit f of the affected vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msi_en | input | 1 | Allows message-mask events to be recorded |
| msix_en | input | 1 | Allows function-mask events to be recorded |
| msi_mask | input | N_FUNC*MSI_BITS | Message mask bits; function f uses the slice starting at f*MSI_BITS |
| msix_mask | input | N_FUNC | Function mask bit of each function |
| clr_msi_off | input | N_FUNC | Write-1-to-clear strobe for sts_msi_off |
| clr_msi_on | input | N_FUNC | Write-1-to-clear strobe for sts_msi_on |
| clr_msix_off | input | N_FUNC | Write-1-to-clear strobe for sts_msix_off |
| clr_msix_on | input | N_FUNC | Write-1-to-clear strobe for sts_msix_on |
| sts_msi_off | output | N_FUNC | Sticky: message mask bit cleared, per function |
| sts_msi_on | output | N_FUNC | Sticky: message mask bit set, per function |
| sts_msix_off | output | N_FUNC | Sticky: function mask cleared, per function |
| sts_msix_on | output | N_FUNC | Sticky: function mask set, per function |
| any_msi_off | output | 1 | OR of sts_msi_off |
| any_msi_on | output | 1 | OR of sts_msi_on |
| any_msix_off | output | 1 | OR of sts_msix_off |
| any_msix_on | output | 1 | OR of sts_msix_on |

## Verification
A wrong previous-cycle copy or a wrong prime flag shows up one edge after a mask change. It appears at the status ports as a missing bit, a bit in the wrong direction, or a false event right after reset. A faulty sticky register either loses a bit while the clear strobe is low, or keeps a bit after a clear with no competing event. Both are visible on the cycle after that edge. Because the summary flags are combinational, a wrong OR shows in the same cycle as the vector that feeds it.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
   // Index of each event class in the per-kind arrays
   typedef enum logic [1:0] {
      EV_MSI_OFF  = 2'd0,
      EV_MSI_ON   = 2'd1,
      EV_MSIX_OFF = 2'd2,
      EV_MSIX_ON  = 2'd3
   } ev_kind_e;

   localparam int unsigned EV_KINDS = 4;
   localparam int unsigned MAX_FUNC = 256;
   localparam int unsigned MAX_MSI_BITS = 32;
endpackage

// File: rtl/mcd_edge.sv
`timescale 1ns/1ps
// Finds any falling or rising bit of a mask against its previous-cycle copy
module mcd_edge #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic         fall,
   output logic         rise
);
   logic [W-1:0] prev_q;
   logic         primed_q;
   logic         gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= din;
         primed_q <= 1'b1;
      end
   end

   assign gate = primed_q & en;

   generate
      if (W == 1) begin : g_bit
         assign fall = gate &  prev_q[0] & ~din[0];
         assign rise = gate & ~prev_q[0] &  din[0];
      end else begin : g_vec
         assign fall = gate & (|(prev_q & ~din));
         assign rise = gate & (|(~prev_q & din));
      end
   endgenerate
endmodule

// File: rtl/mcd_w1c.sv
`timescale 1ns/1ps
// Sticky status vector, write-1-to-clear, a new event wins over a clear
module mcd_w1c #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   logic [N-1:0] q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= '0;
      else        q_q <= (q_q & ~clr) | set;
   end

   assign q = q_q;
endmodule

// File: rtl/mcd_any.sv
`timescale 1ns/1ps
// Summary flag: OR of a status vector
module mcd_any #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] vec,
   output logic         flag
);
   generate
      if (N == 1) begin : g_one
         assign flag = vec[0];
      end else begin : g_many
         assign flag = |vec;
      end
   endgenerate
endmodule

// File: rtl/mask_chg_det.sv
`timescale 1ns/1ps
module mask_chg_det
   import mcd_pkg::*;
#(
   parameter int unsigned N_FUNC   = 4,
   parameter int unsigned MSI_BITS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         msi_en,
   input  logic                         msix_en,
   input  logic [N_FUNC*MSI_BITS-1:0]   msi_mask,
   input  logic [N_FUNC-1:0]            msix_mask,
   input  logic [N_FUNC-1:0]            clr_msi_off,
   input  logic [N_FUNC-1:0]            clr_msi_on,
   input  logic [N_FUNC-1:0]            clr_msix_off,
   input  logic [N_FUNC-1:0]            clr_msix_on,
   output logic [N_FUNC-1:0]            sts_msi_off,
   output logic [N_FUNC-1:0]            sts_msi_on,
   output logic [N_FUNC-1:0]            sts_msix_off,
   output logic [N_FUNC-1:0]            sts_msix_on,
   output logic                         any_msi_off,
   output logic                         any_msi_on,
   output logic                         any_msix_off,
   output logic                         any_msix_on
);
   localparam int unsigned MSI_W = N_FUNC * MSI_BITS;

   // Elaboration-time parameter checks
   generate
      if (N_FUNC < 1 || N_FUNC > MAX_FUNC) begin : g_bad_func
         $error("mask_chg_det: N_FUNC out of range");
      end
      if (MSI_BITS < 1 || MSI_BITS > MAX_MSI_BITS) begin : g_bad_bits
         $error("mask_chg_det: MSI_BITS out of range");
      end
      if (MSI_W != $bits(msi_mask)) begin : g_bad_width
         $error("mask_chg_det: message mask width mismatch");
      end
   endgenerate

   logic [N_FUNC-1:0] ev_msi_off, ev_msi_on, ev_msix_off, ev_msix_on;
   logic [N_FUNC-1:0] ev_set [EV_KINDS];
   logic [N_FUNC-1:0] clr_v  [EV_KINDS];
   logic [N_FUNC-1:0] sts_v  [EV_KINDS];
   logic [EV_KINDS-1:0] any_v;

   // Per-function change detection
   generate
      for (genvar f = 0; f < N_FUNC; f++) begin : g_func
         mcd_edge #(.W(MSI_BITS)) u_msi (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (msi_en),
            .din  (msi_mask[f*MSI_BITS +: MSI_BITS]),
            .fall (ev_msi_off[f]),
            .rise (ev_msi_on[f])
         );
         mcd_edge #(.W(1)) u_msix (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (msix_en),
            .din  (msix_mask[f]),
            .fall (ev_msix_off[f]),
            .rise (ev_msix_on[f])
         );
      end
   endgenerate

   assign ev_set[int'(EV_MSI_OFF)]  = ev_msi_off;
   assign ev_set[int'(EV_MSI_ON)]   = ev_msi_on;
   assign ev_set[int'(EV_MSIX_OFF)] = ev_msix_off;
   assign ev_set[int'(EV_MSIX_ON)]  = ev_msix_on;

   assign clr_v[int'(EV_MSI_OFF)]   = clr_msi_off;
   assign clr_v[int'(EV_MSI_ON)]    = clr_msi_on;
   assign clr_v[int'(EV_MSIX_OFF)]  = clr_msix_off;
   assign clr_v[int'(EV_MSIX_ON)]   = clr_msix_on;

   // Sticky status and summary per event kind
   generate
      for (genvar k = 0; k < EV_KINDS; k++) begin : g_kind
         mcd_w1c #(.N(N_FUNC)) u_sts (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (ev_set[k]),
            .clr  (clr_v[k]),
            .q    (sts_v[k])
         );
         mcd_any #(.N(N_FUNC)) u_any (
            .vec  (sts_v[k]),
            .flag (any_v[k])
         );
      end
   endgenerate

   assign sts_msi_off  = sts_v[int'(EV_MSI_OFF)];
   assign sts_msi_on   = sts_v[int'(EV_MSI_ON)];
   assign sts_msix_off = sts_v[int'(EV_MSIX_OFF)];
   assign sts_msix_on  = sts_v[int'(EV_MSIX_ON)];

   assign any_msi_off  = any_v[int'(EV_MSI_OFF)];
   assign any_msi_on   = any_v[int'(EV_MSI_ON)];
   assign any_msix_off = any_v[int'(EV_MSIX_OFF)];
   assign any_msix_on  = any_v[int'(EV_MSIX_ON)];
endmodule

// File: rtl/mcd_chk.sv
`timescale 1ns/1ps
module mcd_chk #(
   parameter int unsigned N_FUNC   = 4,
   parameter int unsigned MSI_BITS = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       msi_en,
   input logic                       msix_en,
   input logic [N_FUNC*MSI_BITS-1:0] msi_mask,
   input logic [N_FUNC-1:0]          msix_mask,
   input logic [N_FUNC-1:0]          clr_msi_off,
   input logic [N_FUNC-1:0]          clr_msi_on,
   input logic [N_FUNC-1:0]          clr_msix_off,
   input logic [N_FUNC-1:0]          clr_msix_on,
   input logic [N_FUNC-1:0]          sts_msi_off,
   input logic [N_FUNC-1:0]          sts_msi_on,
   input logic [N_FUNC-1:0]          sts_msix_off,
   input logic [N_FUNC-1:0]          sts_msix_on,
   input logic                       any_msi_off,
   input logic                       any_msi_on,
   input logic                       any_msix_off,
   input logic                       any_msix_on
);
   localparam logic [N_FUNC-1:0] ZV = '0;

   // R7: a set bit survives unless its clear strobe was high
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(sts_msi_off) & ~$past(clr_msi_off) & ~sts_msi_off) == ZV) &&
      (($past(sts_msi_on) & ~$past(clr_msi_on) & ~sts_msi_on) == ZV) &&
      (($past(sts_msix_off) & ~$past(clr_msix_off) & ~sts_msix_off) == ZV) &&
      (($past(sts_msix_on) & ~$past(clr_msix_on) & ~sts_msix_on) == ZV));

   // R6: no new message-mask bits while recording is disabled
   p_msi_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(msi_en) |->
         ((sts_msi_off & ~$past(sts_msi_off)) == ZV) &&
         ((sts_msi_on  & ~$past(sts_msi_on))  == ZV));

   // R6: no new function-mask bits while recording is disabled
   p_msix_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(msix_en) |->
         ((sts_msix_off & ~$past(sts_msix_off)) == ZV) &&
         ((sts_msix_on  & ~$past(sts_msix_on))  == ZV));

   // R5: a new function-mask bit needs a matching transition of that function
   p_msix_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_msix_off & ~$past(sts_msix_off) & ~($past(msix_mask, 2) & ~$past(msix_mask))) == ZV) &&
      ((sts_msix_on  & ~$past(sts_msix_on)  & ~(~$past(msix_mask, 2) & $past(msix_mask))) == ZV));

   generate
      for (genvar f = 0; f < N_FUNC; f++) begin : g_cause
         // R2: a new cleared bit needs a 1-to-0 change in that function
         p_msi_off_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_msi_off[f] && !$past(sts_msi_off[f])) |->
               (|($past(msi_mask[f*MSI_BITS +: MSI_BITS], 2) & ~$past(msi_mask[f*MSI_BITS +: MSI_BITS]))));
         // R3: a new set bit needs a 0-to-1 change in that function
         p_msi_on_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_msi_on[f] && !$past(sts_msi_on[f])) |->
               (|(~$past(msi_mask[f*MSI_BITS +: MSI_BITS], 2) & $past(msi_mask[f*MSI_BITS +: MSI_BITS]))));
      end
   endgenerate

   // R9: summary flags track their vectors
   p_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_msi_off == (|sts_msi_off)) && (any_msi_on == (|sts_msi_on)) &&
      (any_msix_off == (|sts_msix_off)) && (any_msix_on == (|sts_msix_on)));
endmodule

bind mask_chg_det mcd_chk #(.N_FUNC(N_FUNC), .MSI_BITS(MSI_BITS)) u_chk (.*);

// File: tb/sim_mask_chg_det.sv
`timescale 1ns/1ps
module sim_mask_chg_det;
   localparam int unsigned NF = 4;
   localparam int unsigned MB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msi_en = 1'b1, msix_en = 1'b1;
   logic [NF*MB-1:0] msi_mask = '0;
   logic [NF-1:0] msix_mask = '0;
   logic [NF-1:0] clr_msi_off = '0, clr_msi_on = '0, clr_msix_off = '0, clr_msix_on = '0;
   logic [NF-1:0] sts_msi_off, sts_msi_on, sts_msix_off, sts_msix_on;
   logic          any_msi_off, any_msi_on, any_msix_off, any_msix_on;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mask_chg_det #(.N_FUNC(NF), .MSI_BITS(MB)) u0 (
      .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .msix_en(msix_en),
      .msi_mask(msi_mask), .msix_mask(msix_mask),
      .clr_msi_off(clr_msi_off), .clr_msi_on(clr_msi_on),
      .clr_msix_off(clr_msix_off), .clr_msix_on(clr_msix_on),
      .sts_msi_off(sts_msi_off), .sts_msi_on(sts_msi_on),
      .sts_msix_off(sts_msix_off), .sts_msix_on(sts_msix_on),
      .any_msi_off(any_msi_off), .any_msi_on(any_msi_on),
      .any_msix_off(any_msix_off), .any_msix_on(any_msix_on)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [3:0] e_off, input logic [3:0] e_on,
                          input logic [3:0] e_xoff, input logic [3:0] e_xon);
      chk({tag, " msi_off"},  32'(sts_msi_off),  32'(e_off));
      chk({tag, " msi_on"},   32'(sts_msi_on),   32'(e_on));
      chk({tag, " msix_off"}, 32'(sts_msix_off), 32'(e_xoff));
      chk({tag, " msix_on"},  32'(sts_msix_on),  32'(e_xon));
      chk({tag, " flags"}, 32'({any_msi_off, any_msi_on, any_msix_off, any_msix_on}),
          32'({|e_off, |e_on, |e_xoff, |e_xon}));
   endtask

   // Reset with given masks; one edge after release is the priming edge
   task automatic do_reset(input logic [31:0] m, input logic [3:0] x);
      @(negedge clk);
      rst_n = 1'b0;
      msi_en = 1'b1; msix_en = 1'b1;
      msi_mask = m; msix_mask = x;
      clr_msi_off = '0; clr_msi_on = '0; clr_msix_off = '0; clr_msix_on = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_prime();
      @(negedge clk);
      rst_n = 1'b0;
      msi_mask = 32'hA5C3_0FF0; msix_mask = 4'b1010;
      #1;
      chk_all("R1 in reset", 4'h0, 4'h0, 4'h0, 4'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_all("R10 prime after reset", 4'h0, 4'h0, 4'h0, 4'h0);
   endtask

   task automatic t_msi_off();
      do_reset(32'hFFFF_FFFF, 4'h0);
      msi_mask[1*MB + 3] = 1'b0;
      @(negedge clk);
      chk_all("R2 R11 msi cleared f1", 4'b0010, 4'h0, 4'h0, 4'h0);
   endtask

   task automatic t_msi_on();
      do_reset(32'h0, 4'h0);
      msi_mask[3*MB + 0] = 1'b1;
      msi_mask[3*MB + 7] = 1'b1;
      @(negedge clk);
      chk_all("R3 R11 msi set f3", 4'h0, 4'b1000, 4'h0, 4'h0);
   endtask

   task automatic t_both();
      do_reset(32'h0000_000F, 4'h0);
      msi_mask[7:0] = 8'hF0;
      @(negedge clk);
      chk_all("R4 both directions f0", 4'b0001, 4'b0001, 4'h0, 4'h0);
   endtask

   task automatic t_msix();
      do_reset(32'h0, 4'b0001);
      msix_mask = 4'b0100;
      @(negedge clk);
      chk_all("R5 function mask f0 off f2 on", 4'h0, 4'h0, 4'b0001, 4'b0100);
   endtask

   task automatic t_gate();
      do_reset(32'h0, 4'h0);
      msi_en = 1'b0;
      msi_mask[0] = 1'b1;
      msix_mask[1] = 1'b1;
      @(negedge clk);
      chk_all("R6 msi gated msix open", 4'h0, 4'h0, 4'h0, 4'b0010);
      msi_en = 1'b1; msix_en = 1'b0;
      @(negedge clk);
      chk_all("R6 no replay on enable", 4'h0, 4'h0, 4'h0, 4'b0010);
      msix_mask[1] = 1'b0;
      @(negedge clk);
      chk_all("R6 msix gated", 4'h0, 4'h0, 4'h0, 4'b0010);
      msix_en = 1'b1;
      msi_mask[2*MB + 4] = 1'b1;
      @(negedge clk);
      chk_all("R6 msi reopened f2", 4'h0, 4'b0100, 4'h0, 4'b0010);
   endtask

   task automatic t_w1c();
      do_reset(32'h0, 4'h0);
      msi_mask[0] = 1'b1;
      msi_mask[MB] = 1'b1;
      @(negedge clk);
      chk_all("R7 two bits set", 4'h0, 4'b0011, 4'h0, 4'h0);
      clr_msi_off = 4'b1111;
      clr_msix_on = 4'b0011;
      repeat (2) @(negedge clk);
      clr_msi_off = '0; clr_msix_on = '0;
      chk_all("R7 other clears no effect", 4'h0, 4'b0011, 4'h0, 4'h0);
      clr_msi_on = 4'b0001;
      @(negedge clk);
      clr_msi_on = '0;
      chk_all("R7 R9 partial clear flag held", 4'h0, 4'b0010, 4'h0, 4'h0);
      @(negedge clk);
      chk_all("R7 hold after clear", 4'h0, 4'b0010, 4'h0, 4'h0);
      clr_msi_on = 4'b0010;
      @(negedge clk);
      clr_msi_on = '0;
      chk_all("R9 last clear drops flag", 4'h0, 4'h0, 4'h0, 4'h0);
   endtask

   task automatic t_collide();
      do_reset(32'h0, 4'h0);
      msix_mask[2] = 1'b1;
      @(negedge clk);
      msix_mask[2] = 1'b0;
      @(negedge clk);
      chk_all("R8 setup", 4'h0, 4'h0, 4'b0100, 4'b0100);
      msix_mask[2] = 1'b1;
      clr_msix_on = 4'b0100;
      @(negedge clk);
      clr_msix_on = '0;
      chk_all("R8 event beats clear", 4'h0, 4'h0, 4'b0100, 4'b0100);
      clr_msix_on = 4'b0100;
      clr_msix_off = 4'b0100;
      @(negedge clk);
      clr_msix_on = '0; clr_msix_off = '0;
      chk_all("R8 plain clear", 4'h0, 4'h0, 4'h0, 4'h0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset_prime();
      t_msi_off();
      t_msi_on();
      t_both();
      t_msix();
      t_gate();
      t_w1c();
      t_collide();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule